// File: doc/BRIEF.md
# Nibble CPU Controller

This block is the sequencer of a very small processor. Its 8-bit instructions come from a 16-word program store, and a finite state machine steps through three fetch cycles and one execute cycle for each instruction. It owns the program counter, the address and buffer registers around the program store, the instruction register, a four-entry register file of 4-bit words, a ripple-carry ALU and the zero and carry flags. The program image is a parameter of the block, so one instance runs one program from reset.

Every instruction has a 2-bit major opcode in bits [7:6]. Opcodes 00, 01 and 10 are arithmetic and logic operations. Bits [5:4] choose the operand form, bits [3:2] name the source (or a small immediate) and bits [1:0] name the destination. Opcode 11 is a control instruction. A nonzero condition field in [5:4] makes it a branch to the address in [3:0]. A zero condition field makes it a switch-load and halt instruction, with its load bit, halt bit and destination in [3], [2] and [1:0].

Each value written to the register file also appears on a registered display output. The program counter and a halt indication are brought out as well.

Top module: `nibble_cpu`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the instruction register, both flags, all four registers, the display output and the halt output, and restarts fetching at address 0.
- R2: Each instruction that is not halted takes exactly four clock cycles. The first cycle latches the program counter as the fetch address. The second reads the program store and increments the program counter by one, wrapping from 15 to 0. The third loads the instruction register. The fourth executes.
- R3: With opcode 00 (add), 01 (subtract) or 10 (AND) and operand form [5:4]=00, the destination register receives destination op source. For subtract this is destination minus source, modulo 16.
- R4: With operand form [5:4]=01, the second operand is the 2-bit field [3:2] zero-extended, in place of a register.
- R5: An opcode 00/01/10 instruction with operand form 10 or 11 writes no register and leaves the flags and the display unchanged.
- R6: Only add, subtract and AND update the flags. Zero is set when the 4-bit result is 0. Carry is the adder carry-out for add, 1 when no borrow occurs (destination >= operand) for subtract, and 0 for AND.
- R7: Opcode 11 with condition [5:4] = 01 branches when zero is set, with 10 branches when carry is set, and with 11 always branches. A taken branch loads the program counter with [3:0]. A branch that is not taken continues at the next address.
- R8: Opcode 11 with condition 00 and bit [3] set copies the 4-bit switch input into the register named by [1:0].
- R9: Opcode 11 with condition 00 and bit [2] set raises the halt output after the execute cycle. The program counter and the display then hold until reset. When bits [3] and [2] are both set, the switch load is done in the same execute cycle.
- R10: The display output takes the value written to the register file at the edge that writes it, and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_in | input | DW (4) | Switch value for the load instruction |
| disp_out | output | DW (4) | Last value written to the register file |
| pc_out | output | IMEM_AW (4) | Program counter |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Counted from the falling edge at which an instruction's fetch begins, the incremented program counter is due after the second rising edge. The register write, the display, the branch target and the halt indication are all due after the fourth rising edge. The bench's reference model steps one instruction per four-cycle window and queues the expected values. The monitor samples at the falling edges that follow rising edges two and four of each window, so every sample lands after the register that produces it has updated. Windows after a halt expect the held values. A reset part-way through checks the cleared state and then reruns the first instructions.

// File: rtl/ncpu_pkg.sv
package ncpu_pkg;

  localparam int IW    = 8;
  localparam int FLD_W = 2;
  localparam int NREG  = 2 ** FLD_W;

  typedef enum logic [2:0] {
    ST_FETCH_ADDR,
    ST_FETCH_READ,
    ST_FETCH_LOAD,
    ST_EXEC,
    ST_HALT
  } cpu_state_t;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_AND  = 2'b10,
    OP_CTRL = 2'b11
  } major_op_t;

  localparam logic [1:0] FORM_REG    = 2'b00;
  localparam logic [1:0] FORM_IMM    = 2'b01;
  localparam logic [1:0] COND_IO     = 2'b00;
  localparam logic [1:0] COND_ZERO   = 2'b01;
  localparam logic [1:0] COND_CARRY  = 2'b10;
  localparam logic [1:0] COND_ALWAYS = 2'b11;

endpackage

// File: rtl/ncpu_rom.sv
module ncpu_rom #(
  parameter int IW    = 8,
  parameter int AW    = 4,
  parameter int DEPTH = 16,
  parameter logic [IW*DEPTH-1:0] IMAGE = '0
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  output logic [IW-1:0] q
);

  logic [IW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = IMAGE[i*IW +: IW];
    end
  end

  // registered read port: this register is the memory buffer register
  always_ff @(posedge clk) begin
    if (rd_en) begin
      q <= mem[addr];
    end
  end

endmodule

// File: rtl/ncpu_regfile.sv
module ncpu_regfile #(
  parameter int DW   = 4,
  parameter int NREG = 4,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [SW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [SW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        regs[i] <= '0;
      end
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

  // R3
  rf_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/ncpu_alu.sv
module ncpu_alu
  import ncpu_pkg::*;
#(
  parameter int DW = 4
) (
  input  major_op_t     op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          cout
);

  logic [DW:0]   chain;
  logic [DW-1:0] b_eff;
  logic [DW-1:0] sum;

  assign b_eff    = (op == OP_SUB) ? ~b : b;
  assign chain[0] = (op == OP_SUB);

  for (genvar i = 0; i < DW; i++) begin : g_fa
    assign sum[i]     = a[i] ^ b_eff[i] ^ chain[i];
    assign chain[i+1] = (a[i] & b_eff[i]) | (chain[i] & (a[i] ^ b_eff[i]));
  end

  always_comb begin
    case (op)
      OP_ADD, OP_SUB: begin
        y    = sum;
        cout = chain[DW];
      end
      OP_AND: begin
        y    = a & b;
        cout = 1'b0;
      end
      default: begin
        y    = '0;
        cout = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/nibble_cpu.sv
module nibble_cpu #(
  parameter int DW      = 4,
  parameter int IMEM_AW = 4,
  parameter logic [ncpu_pkg::IW*(2**IMEM_AW)-1:0] PROGRAM = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DW-1:0]      sw_in,
  output logic [DW-1:0]      disp_out,
  output logic [IMEM_AW-1:0] pc_out,
  output logic               halted
);
  import ncpu_pkg::*;

  localparam int DEPTH = 2 ** IMEM_AW;

  cpu_state_t         state;
  logic [IMEM_AW-1:0] pc;
  logic [IMEM_AW-1:0] mar;
  logic [IW-1:0]      mbr;
  logic [IW-1:0]      ir;
  logic               z_q;
  logic               c_q;
  logic [DW-1:0]      disp_q;
  logic               halt_q;

  // instruction fields
  logic [1:0]       f_op;
  logic [1:0]       f_form;
  logic [FLD_W-1:0] f_src;
  logic [FLD_W-1:0] f_dst;
  logic             f_load;
  logic             f_halt;

  assign f_op   = ir[7:6];
  assign f_form = ir[5:4];
  assign f_src  = ir[3:2];
  assign f_dst  = ir[1:0];
  assign f_load = ir[3];
  assign f_halt = ir[2];

  logic is_ctrl, is_io, is_br, is_alu, taken;

  assign is_ctrl = (f_op == OP_CTRL);
  assign is_io   = is_ctrl && (f_form == COND_IO);
  assign is_br   = is_ctrl && (f_form != COND_IO);
  assign is_alu  = !is_ctrl && ((f_form == FORM_REG) || (f_form == FORM_IMM));

  always_comb begin
    taken = 1'b0;
    if (is_br) begin
      case (f_form)
        COND_ZERO:   taken = z_q;
        COND_CARRY:  taken = c_q;
        COND_ALWAYS: taken = 1'b1;
        default:     taken = 1'b0;
      endcase
    end
  end

  // operand path
  logic [DW-1:0] opa, rf_b, opb, alu_y, wr_data;
  logic          alu_c, wr_en;

  assign opb     = (f_form == FORM_IMM) ? DW'(f_src) : rf_b;
  assign wr_en   = (state == ST_EXEC) && (is_alu || (is_io && f_load));
  assign wr_data = is_alu ? alu_y : sw_in;

  ncpu_rom #(
    .IW(IW), .AW(IMEM_AW), .DEPTH(DEPTH), .IMAGE(PROGRAM)
  ) u_rom (
    .clk   (clk),
    .rd_en (state == ST_FETCH_READ),
    .addr  (mar),
    .q     (mbr)
  );

  ncpu_regfile #(
    .DW(DW), .NREG(NREG)
  ) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .waddr   (f_dst),
    .wdata   (wr_data),
    .raddr_a (f_dst),
    .rdata_a (opa),
    .raddr_b (f_src),
    .rdata_b (rf_b)
  );

  ncpu_alu #(
    .DW(DW)
  ) u_alu (
    .op   (major_op_t'(f_op)),
    .a    (opa),
    .b    (opb),
    .y    (alu_y),
    .cout (alu_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FETCH_ADDR;
      pc     <= '0;
      mar    <= '0;
      ir     <= '0;
      z_q    <= 1'b0;
      c_q    <= 1'b0;
      disp_q <= '0;
      halt_q <= 1'b0;
    end else begin
      case (state)
        ST_FETCH_ADDR: begin
          mar   <= pc;
          state <= ST_FETCH_READ;
        end
        ST_FETCH_READ: begin
          pc    <= pc + IMEM_AW'(1);
          state <= ST_FETCH_LOAD;
        end
        ST_FETCH_LOAD: begin
          ir    <= mbr;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (taken) begin
            pc <= IMEM_AW'(ir[3:0]);
          end
          if (is_alu) begin
            z_q <= (alu_y == '0);
            c_q <= alu_c;
          end
          if (wr_en) begin
            disp_q <= wr_data;
          end
          if (is_io && f_halt) begin
            halt_q <= 1'b1;
            state  <= ST_HALT;
          end else begin
            state  <= ST_FETCH_ADDR;
          end
        end
        ST_HALT: state <= ST_HALT;
        default: state <= ST_FETCH_ADDR;
      endcase
    end
  end

  assign disp_out = disp_q;
  assign pc_out   = pc;
  assign halted   = halt_q;

  // R2
  fetch_seq_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_FETCH_ADDR |=> state == ST_FETCH_READ);
  // R2
  fetch_load_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_FETCH_READ |=> state == ST_FETCH_LOAD);
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_FETCH_READ |=> pc == IMEM_AW'($past(pc) + IMEM_AW'(1)));
  // R3
  add_ripple_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && is_alu && f_op == OP_ADD) |->
      {alu_c, alu_y} == ({1'b0, opa} + {1'b0, opb}));
  // R6
  sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && is_alu && f_op == OP_SUB) |->
      (alu_c == (opa >= opb)) && (alu_y == DW'(opa - opb)));
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && !is_alu) |=> $stable({z_q, c_q}));
  // R7
  br_target_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && taken) |=> pc == IMEM_AW'($past(ir[3:0])));
  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> halt_q && $stable(pc) && $stable(disp_q));
  // R10
  disp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(disp_q));

endmodule

// File: tb/sim_nibble_cpu.sv
module sim_nibble_cpu;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam logic [8*DEPTH-1:0] PROG = {
    8'hCE, 8'h9F, 8'hCB, 8'h10, 8'hFD, 8'h45, 8'h2E, 8'hD0,
    8'h44, 8'h10, 8'h10, 8'hE7, 8'h05, 8'h1D, 8'hC9, 8'h10
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] sw_in = '0;
  logic [3:0] disp_out;
  logic [3:0] pc_out;
  logic       halted;

  nibble_cpu #(.DW(4), .IMEM_AW(4), .PROGRAM(PROG)) u0 (
    .clk(clk), .rst(rst), .sw_in(sw_in),
    .disp_out(disp_out), .pc_out(pc_out), .halted(halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic [3:0] pc_mid;
    logic [3:0] pc_fin;
    logic [3:0] disp;
    logic       halt;
    string      tag;
  } exp_t;

  exp_t sb[$];

  // reference model state
  logic [3:0] m_pc;
  logic [3:0] m_rf [4];
  logic       m_z, m_c, m_halt;
  logic [3:0] m_disp;

  task automatic check(input string tag, input int act, input int exp_v);
    tests++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic model_reset();
    m_pc = '0; m_z = 0; m_c = 0; m_halt = 0; m_disp = '0;
    for (int i = 0; i < 4; i++) m_rf[i] = '0;
  endtask

  function automatic logic [3:0] sw_for(input logic [3:0] pc);
    case (pc)
      4'd1:    return 4'd9;
      4'd13:   return 4'd14;
      4'd15:   return 4'd5;
      default: return 4'(pc * 3);
    endcase
  endfunction

  task automatic model_step(input logic [3:0] sw, output exp_t e);
    logic [7:0] w;
    logic [3:0] a, b, r;
    logic [4:0] s;
    if (m_halt) begin
      e.pc_mid = m_pc; e.pc_fin = m_pc; e.disp = m_disp; e.halt = 1;
      e.tag = "R9";
      return;
    end
    w = PROG[m_pc*8 +: 8];
    m_pc = m_pc + 4'd1;
    e.pc_mid = m_pc;
    e.tag = "R3";
    if (w[7:6] == 2'b11) begin
      if (w[5:4] == 2'b00) begin
        e.tag = "R8";
        if (w[3]) begin m_rf[w[1:0]] = sw; m_disp = sw; end
        if (w[2]) begin m_halt = 1; e.tag = "R9"; end
      end else begin
        e.tag = "R7 R6";
        if (w[5:4] == 2'b11 || (w[5:4] == 2'b01 && m_z) || (w[5:4] == 2'b10 && m_c))
          m_pc = w[3:0];
      end
    end else if (w[5:4] == 2'b00 || w[5:4] == 2'b01) begin
      a = m_rf[w[1:0]];
      b = (w[5:4] == 2'b01) ? {2'b00, w[3:2]} : m_rf[w[3:2]];
      if (w[5:4] == 2'b01) e.tag = "R4";
      case (w[7:6])
        2'b00: begin s = {1'b0, a} + {1'b0, b}; r = s[3:0]; m_c = s[4]; end
        2'b01: begin r = a - b; m_c = (a >= b); end
        default: begin r = a & b; m_c = 0; end
      endcase
      m_z = (r == 4'd0);
      m_rf[w[1:0]] = r;
      m_disp = r;
    end else begin
      e.tag = "R5";
    end
    e.pc_fin = m_pc; e.disp = m_disp; e.halt = m_halt;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pc", pc_out, 0);
    check("R1 disp", disp_out, 0);
    check("R1 halted", halted, 0);
    model_reset();
    rst = 1'b0;
  endtask

  task automatic run_slots(input int n);
    fork
      begin : driver
        for (int s = 0; s < n; s++) begin
          exp_t e;
          sw_in = sw_for(m_pc);
          model_step(sw_in, e);
          sb.push_back(e);
          repeat (4) @(posedge clk);
          @(negedge clk);
        end
      end
      begin : monitor
        for (int s = 0; s < n; s++) begin
          exp_t e;
          repeat (2) @(posedge clk);
          @(negedge clk);
          e = sb.pop_front();
          check("R2 pc after read step", pc_out, e.pc_mid);
          repeat (2) @(posedge clk);
          @(negedge clk);
          check({e.tag, " pc"}, pc_out, e.pc_fin);
          check({"R10 ", e.tag, " disp"}, disp_out, e.disp);
          check("R9 halted", halted, e.halt);
        end
      end
    join
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog: got 0 expected 1 (completion)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    run_slots(19);
    // R1: reset after halt, then registers must read back cleared
    do_reset();
    run_slots(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule